// File: doc/BRIEF.md
# Pipelined 16-bit Processor Bus Controller

This block sits between a processor core and a 16-bit external bus with a 24-bit byte address space, of which only address bits 23:1 leave the chip. The core presents one transfer at a time: an address, a byte or word size, read or write, memory or I/O space, data or control class, and a lock attribute. The controller accepts the transfer, emits a one-clock address strobe together with the address, the two active-low lane enables and the cycle-definition outputs, and keeps the cycle open until the ready input is seen low. Every clock in which ready is high stretches the cycle by one clock. Read data comes back to the core on a one-clock response pulse.

When the system asserts the next-address input during a data clock, the controller puts the following transfer's address and strobe on the bus while the current transfer is still waiting. That transfer then enters its data phase on the clock in which the current one completes. Another bus master can ask for the bus with a hold request. The controller hands the bus over only between transfers, and never between two transfers of a locked sequence. While the bus is handed over it drops its pad enables and raises hold-acknowledge.

The pads themselves are outside this block. Every output comes with an enable: `addr_oe` covers the address, lane enables, definition outputs and strobe, and `dat_oe` covers the write data.

Top module: `pbus_ctrl`

## Requirements
- R1: After reset, `ads_n`, `lock_n`, `be_hi_n` and `be_lo_n` are 1, `hlda`, `dat_oe`, `rsp_valid` and `req_accept` are 0, and `addr_oe` is 1.
- R2: A request taken while idle is accepted (`req_accept`=1) in the clock it is presented. In the next clock `ads_n` is 0 for exactly one clock, `addr_o` carries request address bits 23:1, and the outputs are `wr_o` (1 = write), `dc_o` (1 = data, 0 = control) and `mio_o` (1 = memory, 0 = I/O).
- R3: A byte access at an odd address gives `be_hi_n`=0 and `be_lo_n`=1. A byte access at an even address gives `be_hi_n`=1 and `be_lo_n`=0. A word access (`req_word`=1) gives both enables 0.
- R4: A cycle occupies at least two clocks: the strobe clock, then one or more data clocks. The cycle completes at the end of the first data clock in which `ready_n` is 0, and each data clock with `ready_n`=1 adds one clock. `rsp_valid` is 1 for exactly the clock after completion.
- R5: On the completing edge of a read, `dat_i` is captured into `rsp_rdata`. A word is taken whole. A byte is taken from bits 15:8 (odd address) or 7:0 (even address) and returned in bits 7:0, with bits 15:8 cleared.
- R6: During the data clocks of a write, and only then, `dat_oe` is 1. A word drives `dat_o` with the write data. A byte drives its low 8 data bits on `dat_o[15:8]` (odd address) or `dat_o[7:0]` (even address), and the same byte is replicated on the other lane.
- R7: A request with `na_n` low at a data-clock edge that does not complete the current cycle is accepted at that edge. Its address and strobe appear in the next clock while the current cycle continues, and it enters its own data phase at the current cycle's completing edge. `na_n` is ignored in the strobe clock.
- R8: With `hold`=1, the bus is granted at the next cycle boundary: at once when idle, after completion when busy. While granted, `hlda`=1, `addr_oe`=0, `dat_oe`=0, `ads_n`=1 and no request is accepted. `hlda` falls one clock after `hold` falls.
- R9: `lock_n` is 0 from the strobe clock of a locked transfer. If another locked request is presented on the completing edge, it is accepted and the lock stays 0 even with `hold`=1. Otherwise the lock is released at completion, before any grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core has a transfer pending |
| req_addr | input | 24 | Byte address of the transfer |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_data | input | 1 | 1 = data cycle, 0 = control cycle |
| req_lock | input | 1 | Transfer belongs to a locked sequence |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_accept | output | 1 | Request taken at the coming edge |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, byte right-aligned |
| addr_o | output | 23 | Address bits 23:1 |
| be_hi_n | output | 1 | High-lane enable, active low |
| be_lo_n | output | 1 | Low-lane enable, active low |
| wr_o | output | 1 | 1 = write cycle |
| dc_o | output | 1 | 1 = data cycle, 0 = control |
| mio_o | output | 1 | 1 = memory, 0 = I/O |
| ads_n | output | 1 | Address strobe, active low |
| lock_n | output | 1 | Bus lock, active low |
| ready_n | input | 1 | Cycle-end input, active low |
| na_n | input | 1 | Next-address request, active low |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| addr_oe | output | 1 | Pad enable for address, enables, definition, strobe |
| dat_o | output | 16 | Write data to pads |
| dat_oe | output | 1 | Pad enable for write data |
| dat_i | input | 16 | Read data from pads |

## Verification
The bench drives reads and writes at odd and even byte addresses and whole words, with zero to three wait states. A lane decoder keyed on the wrong address bit would show up as swapped enables or a misplaced byte. A controller that samples ready in the strobe clock would complete one clock early. The pipelined case issues a write while a read is still waiting. Here a design that ignored next-address would hold back the second strobe, and one that let the new cycle's write direction reach the data drivers early would drive the bus during a read. The hold cases raise the request when idle, in the middle of a cycle, and across a locked pair. A grant taken mid-cycle or between the two locked transfers shows up as an early `hlda` or a broken lock.

// File: rtl/pbus_pkg.sv
`timescale 1ns/1ps
package pbus_pkg;

    localparam int PA_W  = 24;
    localparam int DW    = 16;
    localparam int LANE  = 8;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_HOLD = 2'd3
    } phase_e;

    // Data-phase view of a transfer: what the lane logic needs.
    typedef struct packed {
        logic          word;
        logic          odd;
        logic          write;
        logic [DW-1:0] wdata;
    } dphase_t;

    // Active-high lane use, {high, low}.
    function automatic logic [1:0] lane_use(input logic word, input logic odd);
        return {word | odd, word | ~odd};
    endfunction

    function automatic logic [DW-1:0] align_read(input dphase_t d, input logic [DW-1:0] bus);
        logic [DW-1:0] r;
        if (d.word)     r = bus;
        else if (d.odd) r = {{(DW-LANE){1'b0}}, bus[DW-1:LANE]};
        else            r = {{(DW-LANE){1'b0}}, bus[LANE-1:0]};
        return r;
    endfunction

endpackage

// File: rtl/pbus_aphase.sv
`timescale 1ns/1ps
module pbus_aphase
    import pbus_pkg::*;
#(
    parameter int ADDR_W = PA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    input  logic              write,
    input  logic              mem,
    input  logic              data,
    output logic [ADDR_W-1:1] addr_q,
    output logic              be_hi_n,
    output logic              be_lo_n,
    output logic              wr_q,
    output logic              dc_q,
    output logic              mio_q,
    output logic              ads_n
);

    logic [1:0] use_w;
    assign use_w = lane_use(word, addr[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            be_hi_n <= 1'b1;
            be_lo_n <= 1'b1;
            wr_q    <= 1'b0;
            dc_q    <= 1'b0;
            mio_q   <= 1'b0;
            ads_n   <= 1'b1;
        end else begin
            ads_n <= ~load;
            if (load) begin
                addr_q  <= addr[ADDR_W-1:1];
                be_hi_n <= ~use_w[1];
                be_lo_n <= ~use_w[0];
                wr_q    <= write;
                dc_q    <= data;
                mio_q   <= mem;
            end
        end
    end

endmodule

// File: rtl/pbus_lane.sv
`timescale 1ns/1ps
module pbus_lane
    import pbus_pkg::*;
(
    input  dphase_t       cur,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [DW-1:0] rd_align
);

    localparam int NLANE = DW / LANE;

    // Bytes are replicated on every lane; words pass straight through.
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign dout[g*LANE +: LANE] = cur.word ? cur.wdata[g*LANE +: LANE]
                                               : cur.wdata[LANE-1:0];
    end

    assign rd_align = align_read(cur, din);

endmodule

// File: rtl/pbus_seq.sv
`timescale 1ns/1ps
module pbus_seq
    import pbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    req_locked,
    input  dphase_t req_dp,
    input  logic    ready_n,
    input  logic    na_n,
    input  logic    hold,
    output logic    accept,
    output logic    done,
    output logic    in_data,
    output logic    lock_q,
    output logic    hlda,
    output dphase_t cur
);

    phase_e  ph;
    logic    pend;
    dphase_t nxt;

    logic boundary, lock_cont, start_b, grant, pipe;

    always_comb begin
        in_data   = (ph == PH_DATA);
        done      = in_data & ~ready_n;
        boundary  = (ph == PH_IDLE) | (done & ~pend);
        lock_cont = lock_q & req_valid & req_locked;
        start_b   = boundary & (lock_cont | (~hold & req_valid));
        grant     = boundary & ~lock_cont & hold;
        pipe      = in_data & ~done & ~pend & ~na_n & req_valid & ~hold
                    & (req_locked == lock_q);
        accept    = start_b | pipe;
        hlda      = (ph == PH_HOLD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            pend   <= 1'b0;
            lock_q <= 1'b0;
            cur    <= '0;
            nxt    <= '0;
        end else if (start_b) begin
            cur    <= req_dp;
            ph     <= PH_ADDR;
            lock_q <= req_locked;
        end else if (grant) begin
            ph     <= PH_HOLD;
            lock_q <= 1'b0;
        end else if (boundary) begin
            ph     <= PH_IDLE;
            lock_q <= 1'b0;
        end else begin
            case (ph)
                PH_ADDR: ph <= PH_DATA;
                PH_HOLD: if (!hold) ph <= PH_IDLE;
                PH_DATA: begin
                    if (done) begin
                        cur  <= nxt;
                        pend <= 1'b0;
                    end else if (pipe) begin
                        nxt  <= req_dp;
                        pend <= 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pbus_ctrl.sv
`timescale 1ns/1ps
module pbus_ctrl
    import pbus_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [PA_W-1:0] req_addr,
    input  logic            req_word,
    input  logic            req_write,
    input  logic            req_mem,
    input  logic            req_data,
    input  logic            req_lock,
    input  logic [DW-1:0]   req_wdata,
    output logic            req_accept,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_rdata,
    output logic [PA_W-1:1] addr_o,
    output logic            be_hi_n,
    output logic            be_lo_n,
    output logic            wr_o,
    output logic            dc_o,
    output logic            mio_o,
    output logic            ads_n,
    output logic            lock_n,
    input  logic            ready_n,
    input  logic            na_n,
    input  logic            hold,
    output logic            hlda,
    output logic            addr_oe,
    output logic [DW-1:0]   dat_o,
    output logic            dat_oe,
    input  logic [DW-1:0]   dat_i
);

    dphase_t req_dp, cur;
    logic    done, in_data, lock_q;
    logic [DW-1:0] rd_align;

    assign req_dp = '{word: req_word, odd: req_addr[0], write: req_write, wdata: req_wdata};

    pbus_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_locked (req_lock),
        .req_dp     (req_dp),
        .ready_n    (ready_n),
        .na_n       (na_n),
        .hold       (hold),
        .accept     (req_accept),
        .done       (done),
        .in_data    (in_data),
        .lock_q     (lock_q),
        .hlda       (hlda),
        .cur        (cur)
    );

    pbus_aphase #(.ADDR_W(PA_W)) u_aph (
        .clk     (clk),
        .rst     (rst),
        .load    (req_accept),
        .addr    (req_addr),
        .word    (req_word),
        .write   (req_write),
        .mem     (req_mem),
        .data    (req_data),
        .addr_q  (addr_o),
        .be_hi_n (be_hi_n),
        .be_lo_n (be_lo_n),
        .wr_q    (wr_o),
        .dc_q    (dc_o),
        .mio_q   (mio_o),
        .ads_n   (ads_n)
    );

    pbus_lane u_lane (
        .cur      (cur),
        .din      (dat_i),
        .dout     (dat_o),
        .rd_align (rd_align)
    );

    assign lock_n  = ~lock_q;
    assign addr_oe = ~hlda;
    assign dat_oe  = in_data & cur.write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (done && !cur.write) rsp_rdata <= rd_align;
        end
    end

endmodule

// File: rtl/pbus_ctrl_chk.sv
`timescale 1ns/1ps
module pbus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ads_n,
    input logic be_hi_n,
    input logic be_lo_n,
    input logic addr_oe,
    input logic dat_oe,
    input logic lock_n,
    input logic hlda,
    input logic hold
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst) !ads_n |=> ads_n); // R2
    AST_LANE_PRESENT:  assert property (@(posedge clk) disable iff (rst) !ads_n |-> !(be_hi_n && be_lo_n)); // R3
    AST_GRANT_FLOAT:   assert property (@(posedge clk) disable iff (rst) hlda |-> (!addr_oe && !dat_oe && ads_n)); // R8
    AST_GRANT_ASKED:   assert property (@(posedge clk) disable iff (rst) $rose(hlda) |-> $past(hold)); // R8
    AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (rst) (hlda && !hold) |=> !hlda); // R8
    AST_GRANT_UNLOCK:  assert property (@(posedge clk) disable iff (rst) hlda |-> lock_n); // R9

endmodule

bind pbus_ctrl pbus_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ads_n   (ads_n),
    .be_hi_n (be_hi_n),
    .be_lo_n (be_lo_n),
    .addr_oe (addr_oe),
    .dat_oe  (dat_oe),
    .lock_n  (lock_n),
    .hlda    (hlda),
    .hold    (hold)
);

// File: tb/tb_pbus_ctrl.sv
`timescale 1ns/1ps
module tb_pbus_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_word = 1'b0, req_write = 1'b0, req_mem = 1'b0, req_data = 1'b0, req_lock = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_accept, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [23:1] addr_o;
    logic        be_hi_n, be_lo_n, wr_o, dc_o, mio_o, ads_n, lock_n, hlda, addr_oe, dat_oe;
    logic        ready_n = 1'b1, na_n = 1'b1, hold = 1'b0;
    logic [15:0] dat_o;
    logic [15:0] dat_i = '0;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pbus_ctrl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_word(req_word),
        .req_write(req_write), .req_mem(req_mem), .req_data(req_data), .req_lock(req_lock),
        .req_wdata(req_wdata), .req_accept(req_accept), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .addr_o(addr_o), .be_hi_n(be_hi_n), .be_lo_n(be_lo_n), .wr_o(wr_o), .dc_o(dc_o), .mio_o(mio_o),
        .ads_n(ads_n), .lock_n(lock_n), .ready_n(ready_n), .na_n(na_n), .hold(hold), .hlda(hlda),
        .addr_oe(addr_oe), .dat_o(dat_o), .dat_oe(dat_oe), .dat_i(dat_i)
    );

    typedef struct packed {
        logic [23:0] addr;
        logic        word, write, mem, data;
        logic [3:0]  waits;
        logic        hi_n, lo_n;
        logic [15:0] wdata, bus, dmask, dexp, rexp;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{24'h000100, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0, 1'b0, 1'b0, 16'h0000, 16'hA55A, 16'h0000, 16'h0000, 16'hA55A},
        '{24'h123457, 1'b0, 1'b0, 1'b1, 1'b1, 4'd1, 1'b0, 1'b1, 16'h0000, 16'hBEEF, 16'h0000, 16'h0000, 16'h00BE},
        '{24'hFFFFFE, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2, 1'b1, 1'b0, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 16'h0034},
        '{24'h000A02, 1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 1'b0, 1'b0, 16'hC0DE, 16'h0000, 16'hFFFF, 16'hC0DE, 16'h0000},
        '{24'h800001, 1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 1'b0, 1'b1, 16'h0077, 16'h0000, 16'hFF00, 16'h7700, 16'h0000},
        '{24'h000010, 1'b0, 1'b1, 1'b1, 1'b0, 4'd1, 1'b1, 1'b0, 16'h00E1, 16'h0000, 16'h00FF, 16'h00E1, 16'h0000}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put_req(input logic [23:0] a, input logic w, input logic wr, input logic m,
                           input logic d, input logic lk, input logic [15:0] wd);
        req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr;
        req_mem = m; req_data = d; req_lock = lk; req_wdata = wd;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ads_n", ads_n, 1); chk("R1", "lock_n", lock_n, 1);
        chk("R1", "be", {be_hi_n, be_lo_n}, 2'b11); chk("R1", "hlda", hlda, 0);
        chk("R1", "dat_oe", dat_oe, 0); chk("R1", "rsp_valid", rsp_valid, 0);
        chk("R1", "req_accept", req_accept, 0); chk("R1", "addr_oe", addr_oe, 1);

        // Vector walk: R2 R3 R4 R5 R6
        foreach (VEC[k]) begin
            @(negedge clk);
            put_req(VEC[k].addr, VEC[k].word, VEC[k].write, VEC[k].mem, VEC[k].data, 1'b0, VEC[k].wdata);
            ready_n = 1'b1; #1;
            chk("R2", "accept", req_accept, 1);
            @(negedge clk);
            req_valid = 1'b0;
            chk("R2", "ads_n strobe", ads_n, 0);
            chk("R2", "addr", addr_o, VEC[k].addr[23:1]);
            chk("R2", "defs", {wr_o, dc_o, mio_o}, {VEC[k].write, VEC[k].data, VEC[k].mem});
            chk("R3", "lanes", {be_hi_n, be_lo_n}, {VEC[k].hi_n, VEC[k].lo_n});
            chk("R6", "no drive in strobe clock", dat_oe, 0);
            for (int i = 0; i <= int'(VEC[k].waits); i++) begin
                @(negedge clk);
                chk("R2", "ads_n after strobe", ads_n, 1);
                chk("R4", "no early response", rsp_valid, 0);
                chk("R6", "drive enable", dat_oe, VEC[k].write);
                if (VEC[k].write) chk("R6", "write lane", dat_o & VEC[k].dmask, VEC[k].dexp);
                ready_n = (i == int'(VEC[k].waits)) ? 1'b0 : 1'b1;
                dat_i   = VEC[k].bus;
            end
            @(negedge clk);
            ready_n = 1'b1;
            chk("R4", "response pulse", rsp_valid, 1);
            if (!VEC[k].write) chk("R5", "read data", rsp_rdata, VEC[k].rexp);
            @(negedge clk);
            chk("R4", "pulse one clock", rsp_valid, 0);
        end

        // R7 pipelined issue: read word, then byte write at odd address
        @(negedge clk);
        put_req(24'h000200, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000);
        @(negedge clk);
        put_req(24'h000301, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h00C3);
        na_n = 1'b0; #1;
        chk("R7", "no accept in strobe clock", req_accept, 0);
        @(negedge clk); #1;
        chk("R7", "pipelined accept", req_accept, 1);
        @(negedge clk);
        req_valid = 1'b0; na_n = 1'b1;
        chk("R7", "early strobe", ads_n, 0);
        chk("R7", "early addr", addr_o, 23'h000180);
        chk("R7", "early lanes", {be_hi_n, be_lo_n}, 2'b01);
        chk("R6", "read still in data phase", dat_oe, 0);
        chk("R7", "first not done", rsp_valid, 0);
        ready_n = 1'b0; dat_i = 16'h7E81;
        @(negedge clk);
        chk("R7", "first done", rsp_valid, 1);
        chk("R5", "first read data", rsp_rdata, 16'h7E81);
        chk("R7", "second in data phase", dat_oe, 1);
        chk("R6", "odd byte lane", dat_o[15:8], 8'hC3);
        @(negedge clk);
        ready_n = 1'b1;
        chk("R7", "second done", rsp_valid, 1);
        chk("R6", "drive released", dat_oe, 0);

        // R8 hold while idle
        @(negedge clk);
        hold = 1'b1;
        @(negedge clk);
        put_req(24'h000004, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0000); #1;
        chk("R8", "hlda idle grant", hlda, 1);
        chk("R8", "addr float", addr_oe, 0);
        chk("R8", "no accept while granted", req_accept, 0);
        req_valid = 1'b0; hold = 1'b0;
        @(negedge clk);
        chk("R8", "hlda released", hlda, 0);
        chk("R8", "addr driven again", addr_oe, 1);
        chk("R8", "nothing started", ads_n, 1);

        // R9 locked pair with hold raised mid-cycle, R8 grant after the pair
        @(negedge clk);
        put_req(24'h000040, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1111);
        @(negedge clk);
        req_valid = 1'b0; hold = 1'b1;
        chk("R9", "lock at strobe", lock_n, 0);
        @(negedge clk);
        chk("R8", "no grant mid-cycle", hlda, 0);
        put_req(24'h000041, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h0000);
        ready_n = 1'b0; #1;
        chk("R9", "locked continuation accepted", req_accept, 1);
        @(negedge clk);
        req_valid = 1'b0; dat_i = 16'h5A77;
        chk("R9", "no grant inside lock", hlda, 0);
        chk("R9", "lock held", lock_n, 0);
        chk("R9", "second strobe", ads_n, 0);
        @(negedge clk);
        chk("R9", "lock held in data", lock_n, 0);
        @(negedge clk);
        ready_n = 1'b1;
        chk("R8", "grant after pair", hlda, 1);
        chk("R9", "lock released", lock_n, 1);
        chk("R8", "data float", dat_oe, 0);
        chk("R5", "odd byte read", rsp_rdata, 16'h005A);
        hold = 1'b0;
        @(negedge clk);
        chk("R8", "release after hold drop", hlda, 0);

        finish_run();
    end

endmodule